// File: doc/BRIEF.md
# I2C-to-SPI bridge command engine

This block is the command layer of a bridge that lets a host on an I2C bus drive devices on an SPI bus. A byte-level I2C front end hands it start and stop events, received bytes and read requests. The block answers each of these with an ACK decision or a read byte. The first byte after its own address names a function. That byte either picks a chip-select line or asks for the SPI control byte to be loaded. The data bytes that follow are kept in a local buffer.

When the host ends the write with a stop or a repeated start, the block runs one framed SPI transaction over the stored bytes. The selected chip select is held low for the whole transaction. A bit-level shifter outside this block moves each byte, and each byte it returns replaces the one sent from the same buffer slot. The host then reads the replies with an ordinary I2C read. While a transaction is pending the block refuses its own address, so the host can poll until it gets an ACK.

Top module: `i2c_spi_bridge`

## Requirements
- R1: Out of reset every chip-select output is high, `busy_o` is low, `cfg_o` is 0x00 and no ACK strobe is given.
- R2: The first byte after a start is the address byte: bits [7:1] hold the address and bit 0 is 1 for a read. The block ACKs when bits [7:1] equal `SLV_ADDR` and no transaction is pending. Otherwise it NACKs and NACKs every byte until the next start or stop. Every received byte gets exactly one ACK strobe one cycle later.
- R3: In a write, a function byte of 0x01, 0x02, 0x04 or 0x08 selects chip-select line 0, 1, 2 or 3 (set bit n selects line n). Chip-select outputs are active low.
- R4: Data bytes after a chip-select function are ACKed and stored. A stop or repeated start that ends such a write starts one SPI transaction. The transaction sends the bytes in arrival order, keeping only the selected line low from before the first byte until after the last.
- R5: The byte returned by the shifter for each position overwrites that buffer position. A read transfer returns buffer bytes starting at position 0 and stepping by one for each read request.
- R6: From the end of a write that starts a transaction until the last byte returns, the block NACKs its own address. A host polling with address-only reads gets an ACK once the transaction is over.
- R7: The function byte 0xF0 loads the next byte into `cfg_o`. Later bytes in that write are NACKed, and no transaction starts.
- R8: At most 200 (`DEPTH`) data bytes are stored per write. Bytes beyond that are NACKed and dropped, and the transaction that follows moves exactly 200 bytes.
- R9: A write that carries a function byte but no data byte starts no transaction.
- R10: A function byte that selects a line that is absent, either at or above `NUM_CS` or line 2 when `SKIP_CS2` is set, is ACKed. The same holds for any other value that is neither a one-hot low nibble with a zero high nibble nor 0xF0. In either case the following data bytes are NACKed, no output goes low, no transaction starts, and the buffer keeps its contents.
- R11: At most one chip-select output is low at any time, and none is low while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bl_start_i | input | 1 | Start or repeated start seen on the bus (one-cycle pulse) |
| bl_stop_i | input | 1 | Stop seen on the bus (one-cycle pulse) |
| bl_byte_vld_i | input | 1 | A byte from the host is complete (one-cycle pulse) |
| bl_byte_i | input | 8 | The received byte, valid with `bl_byte_vld_i` |
| bl_rd_req_i | input | 1 | The host wants the next read byte (one-cycle pulse) |
| bl_ack_vld_o | output | 1 | ACK decision valid, one cycle after `bl_byte_vld_i` |
| bl_ack_o | output | 1 | 1 = ACK, 0 = NACK |
| bl_rd_data_o | output | 8 | Read byte, updated one cycle after `bl_rd_req_i` |
| busy_o | output | 1 | SPI transaction pending or running |
| cfg_o | output | 8 | SPI control byte for the shifter |
| sh_start_o | output | 1 | Ask the shifter to move `sh_tx_o` |
| sh_tx_o | output | 8 | Byte to send |
| sh_done_i | input | 1 | Shifter finished a byte (one-cycle pulse) |
| sh_rx_i | input | 8 | Byte received, valid with `sh_done_i` |
| cs_n_o | output | NUM_CS | Active-low chip selects |

## Verification
The main function is tried with short writes to lines 0 and 3, with different byte patterns and with a stop and a repeated start as the end marker. This separates correct ordering and line choice from swapped or stuck lines, and shows that either end condition launches the transaction. A full 201-byte write tells a correct length cap from an off-by-one, and reading back all 200 replies shows that each returned byte lands in the slot it was sent from. Writes with only a function byte, with the configure code, with an absent line, with a malformed function and with a foreign address must leave the SPI side silent. Each is told apart by its ACK pattern and by the unchanged buffer.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_FUNC,
        PH_CFG,
        PH_WDATA,
        PH_DROP,
        PH_READ
    } host_phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } seq_state_e;

    localparam logic [7:0] FN_CONFIG = 8'hF0;

endpackage

// File: rtl/bridge_fn_decode.sv
module bridge_fn_decode #(
    parameter int NUM_CS   = 4,
    parameter bit SKIP_CS2 = 1'b0
) (
    input  logic [7:0]        fn_i,
    output logic              sel_ok_o,
    output logic [NUM_CS-1:0] mask_o
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        if (SKIP_CS2 && i == 2) begin : g_absent
            assign mask_o[i] = 1'b0;
        end else begin : g_present
            assign mask_o[i] = fn_i[i];
        end
    end

    always_comb begin
        sel_ok_o = (fn_i[7:4] == 4'h0) && $onehot(fn_i[3:0]) && (|mask_o);
    end

endmodule

// File: rtl/bridge_buffer.sv
module bridge_buffer #(
    parameter int DEPTH = 200,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    input  logic [AW-1:0] rd_a_addr_i,
    output logic [7:0]    rd_a_data_o,
    input  logic [AW-1:0] rd_b_addr_i,
    output logic [7:0]    rd_b_data_o
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    always_comb begin
        rd_a_data_o = mem_q[rd_a_addr_i];
        rd_b_data_o = mem_q[rd_b_addr_i];
    end

endmodule

// File: rtl/bridge_host_fsm.sv
module bridge_host_fsm
    import bridge_pkg::*;
#(
    parameter int         DEPTH    = 200,
    parameter int         NUM_CS   = 4,
    parameter logic [6:0] SLV_ADDR = 7'h51,
    localparam int        AW       = $clog2(DEPTH),
    localparam int        CW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              rd_req_i,
    input  logic              busy_i,
    input  logic              dec_ok_i,
    input  logic [NUM_CS-1:0] dec_mask_i,
    input  logic [7:0]        buf_rdata_i,
    output logic              ack_vld_o,
    output logic              ack_o,
    output logic [7:0]        rd_data_o,
    output logic [7:0]        cfg_o,
    output logic              launch_o,
    output logic [CW-1:0]     len_o,
    output logic [NUM_CS-1:0] mask_o,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic [AW-1:0]     rd_addr_o,
    output logic              addr_phase_o
);

    localparam logic [CW-1:0] CAP      = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        host_phase_e       phase;
        logic [CW-1:0]     cnt;
        logic [NUM_CS-1:0] mask;
        logic [AW-1:0]     rptr;
        logic              ack_vld;
        logic              ack;
        logic [7:0]        rdat;
        logic              launch;
        logic [7:0]        cfg;
    } host_t;

    host_t q, d;
    logic  wr_en;
    logic  end_of_write;

    always_comb begin
        d            = q;
        d.ack_vld    = 1'b0;
        d.ack        = 1'b0;
        d.launch     = 1'b0;
        wr_en        = 1'b0;
        end_of_write = (q.phase == PH_WDATA) && (q.cnt != '0);

        if (start_i) begin
            d.launch = end_of_write;
            d.phase  = PH_ADDR;
        end else if (stop_i) begin
            d.launch = end_of_write;
            d.phase  = PH_IDLE;
        end else if (byte_vld_i) begin
            d.ack_vld = 1'b1;
            unique case (q.phase)
                PH_ADDR: begin
                    if (byte_i[7:1] == SLV_ADDR && !busy_i) begin
                        d.ack = 1'b1;
                        if (byte_i[0]) begin
                            d.phase = PH_READ;
                            d.rptr  = '0;
                        end else begin
                            d.phase = PH_FUNC;
                        end
                    end else begin
                        d.phase = PH_DROP;
                    end
                end
                PH_FUNC: begin
                    d.ack = 1'b1;
                    d.cnt = '0;
                    if (byte_i == FN_CONFIG) begin
                        d.phase = PH_CFG;
                    end else if (dec_ok_i) begin
                        d.phase = PH_WDATA;
                        d.mask  = dec_mask_i;
                    end else begin
                        d.phase = PH_DROP;
                    end
                end
                PH_CFG: begin
                    d.ack   = 1'b1;
                    d.cfg   = byte_i;
                    d.phase = PH_DROP;
                end
                PH_WDATA: begin
                    if (q.cnt < CAP) begin
                        d.ack = 1'b1;
                        wr_en = 1'b1;
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                default: begin
                end
            endcase
        end else if (rd_req_i && q.phase == PH_READ) begin
            d.rdat = buf_rdata_i;
            if (q.rptr != LAST_IDX) begin
                d.rptr = q.rptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ack_vld_o    = q.ack_vld;
        ack_o        = q.ack;
        rd_data_o    = q.rdat;
        cfg_o        = q.cfg;
        launch_o     = q.launch;
        len_o        = q.cnt;
        mask_o       = q.mask;
        wr_en_o      = wr_en;
        wr_addr_o    = q.cnt[AW-1:0];
        wr_data_o    = byte_i;
        rd_addr_o    = q.rptr;
        addr_phase_o = (q.phase == PH_ADDR);
    end

endmodule

// File: rtl/bridge_spi_seq.sv
module bridge_spi_seq
    import bridge_pkg::*;
#(
    parameter int  DEPTH  = 200,
    parameter int  NUM_CS = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic [CW-1:0]     len_i,
    input  logic [NUM_CS-1:0] mask_i,
    input  logic              done_i,
    output logic              sh_start_o,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [AW-1:0]     idx_o,
    output logic [NUM_CS-1:0] cs_n_o
);

    typedef struct packed {
        seq_state_e        state;
        logic [AW-1:0]     idx;
        logic [AW-1:0]     last;
        logic [NUM_CS-1:0] cs_n;
    } seq_t;

    seq_t q, d;
    logic wr_en;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        unique case (q.state)
            SQ_IDLE: begin
                if (launch_i) begin
                    d.state = SQ_ISSUE;
                    d.idx   = '0;
                    d.last  = AW'(len_i - CW'(1));
                    d.cs_n  = ~mask_i;
                end
            end
            SQ_ISSUE: begin
                d.state = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (done_i) begin
                    wr_en = 1'b1;
                    if (q.idx == q.last) begin
                        d.state = SQ_IDLE;
                        d.cs_n  = '1;
                    end else begin
                        d.idx   = q.idx + AW'(1);
                        d.state = SQ_ISSUE;
                    end
                end
            end
            default: begin
                d.state = SQ_IDLE;
                d.cs_n  = '1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SQ_IDLE, idx: '0, last: '0, cs_n: '1};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        sh_start_o = (q.state == SQ_ISSUE);
        busy_o     = (q.state != SQ_IDLE);
        wr_en_o    = wr_en;
        idx_o      = q.idx;
        cs_n_o     = q.cs_n;
    end

endmodule

// File: rtl/i2c_spi_bridge.sv
module i2c_spi_bridge #(
    parameter int         DEPTH    = 200,
    parameter int         NUM_CS   = 4,
    parameter bit         SKIP_CS2 = 1'b0,
    parameter logic [6:0] SLV_ADDR = 7'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bl_start_i,
    input  logic              bl_stop_i,
    input  logic              bl_byte_vld_i,
    input  logic [7:0]        bl_byte_i,
    input  logic              bl_rd_req_i,
    output logic              bl_ack_vld_o,
    output logic              bl_ack_o,
    output logic [7:0]        bl_rd_data_o,
    output logic              busy_o,
    output logic [7:0]        cfg_o,
    output logic              sh_start_o,
    output logic [7:0]        sh_tx_o,
    input  logic              sh_done_i,
    input  logic [7:0]        sh_rx_i,
    output logic [NUM_CS-1:0] cs_n_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic              dec_ok;
    logic [NUM_CS-1:0] dec_mask;
    logic              host_launch;
    logic [CW-1:0]     host_len;
    logic [NUM_CS-1:0] host_mask;
    logic              host_wr_en;
    logic [AW-1:0]     host_wr_addr;
    logic [7:0]        host_wr_data;
    logic [AW-1:0]     host_rd_addr;
    logic [7:0]        host_rd_data;
    logic              host_addr_phase;
    logic              seq_busy;
    logic              seq_wr_en;
    logic [AW-1:0]     seq_idx;
    logic              busy;
    logic              buf_wr_en;
    logic [AW-1:0]     buf_wr_addr;
    logic [7:0]        buf_wr_data;

    always_comb begin
        busy        = host_launch | seq_busy;
        busy_o      = busy;
        buf_wr_en   = seq_wr_en | host_wr_en;
        buf_wr_addr = seq_wr_en ? seq_idx : host_wr_addr;
        buf_wr_data = seq_wr_en ? sh_rx_i : host_wr_data;
    end

    bridge_fn_decode #(
        .NUM_CS   (NUM_CS),
        .SKIP_CS2 (SKIP_CS2)
    ) u_decode (
        .fn_i     (bl_byte_i),
        .sel_ok_o (dec_ok),
        .mask_o   (dec_mask)
    );

    bridge_host_fsm #(
        .DEPTH    (DEPTH),
        .NUM_CS   (NUM_CS),
        .SLV_ADDR (SLV_ADDR)
    ) u_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (bl_start_i),
        .stop_i       (bl_stop_i),
        .byte_vld_i   (bl_byte_vld_i),
        .byte_i       (bl_byte_i),
        .rd_req_i     (bl_rd_req_i),
        .busy_i       (busy),
        .dec_ok_i     (dec_ok),
        .dec_mask_i   (dec_mask),
        .buf_rdata_i  (host_rd_data),
        .ack_vld_o    (bl_ack_vld_o),
        .ack_o        (bl_ack_o),
        .rd_data_o    (bl_rd_data_o),
        .cfg_o        (cfg_o),
        .launch_o     (host_launch),
        .len_o        (host_len),
        .mask_o       (host_mask),
        .wr_en_o      (host_wr_en),
        .wr_addr_o    (host_wr_addr),
        .wr_data_o    (host_wr_data),
        .rd_addr_o    (host_rd_addr),
        .addr_phase_o (host_addr_phase)
    );

    bridge_spi_seq #(
        .DEPTH  (DEPTH),
        .NUM_CS (NUM_CS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (host_launch),
        .len_i      (host_len),
        .mask_i     (host_mask),
        .done_i     (sh_done_i),
        .sh_start_o (sh_start_o),
        .busy_o     (seq_busy),
        .wr_en_o    (seq_wr_en),
        .idx_o      (seq_idx),
        .cs_n_o     (cs_n_o)
    );

    bridge_buffer #(
        .DEPTH (DEPTH)
    ) u_buf (
        .clk         (clk),
        .wr_en_i     (buf_wr_en),
        .wr_addr_i   (buf_wr_addr),
        .wr_data_i   (buf_wr_data),
        .rd_a_addr_i (host_rd_addr),
        .rd_a_data_o (host_rd_data),
        .rd_b_addr_i (seq_idx),
        .rd_b_data_o (sh_tx_o)
    );

endmodule

// File: rtl/i2c_spi_bridge_chk.sv
module i2c_spi_bridge_chk #(
    parameter int NUM_CS   = 4,
    parameter bit SKIP_CS2 = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              byte_vld_i,
    input logic              ack_vld_i,
    input logic              ack_i,
    input logic              addr_phase_i,
    input logic              busy_i,
    input logic              sh_start_i,
    input logic [NUM_CS-1:0] cs_n_i
);

    // R2: one ACK decision per received byte, in the following cycle
    p_ack_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_i |=> ack_vld_i);

    p_ack_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_i |-> $past(byte_vld_i));

    // R6: address byte during a pending transaction is refused
    p_addr_nack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && addr_phase_i && busy_i) |=> (ack_vld_i && !ack_i));

    // R4: a transaction only begins at the end of a write
    p_busy_from_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> $past(start_i || stop_i));

    // R4: every byte moved on SPI has a line selected
    p_byte_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start_i |-> !(&cs_n_i));

    // R11: at most one line low, none while idle
    p_cs_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n_i) <= 1);

    p_cs_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (&cs_n_i));

    if (SKIP_CS2 && NUM_CS > 2) begin : g_cs2
        // R10: an absent line never goes low
        p_cs2_absent_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cs_n_i[2]);
    end

endmodule

bind i2c_spi_bridge i2c_spi_bridge_chk #(
    .NUM_CS   (NUM_CS),
    .SKIP_CS2 (SKIP_CS2)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (bl_start_i),
    .stop_i       (bl_stop_i),
    .byte_vld_i   (bl_byte_vld_i),
    .ack_vld_i    (bl_ack_vld_o),
    .ack_i        (bl_ack_o),
    .addr_phase_i (host_addr_phase),
    .busy_i       (busy),
    .sh_start_i   (sh_start_o),
    .cs_n_i       (cs_n_o)
);

// File: tb/i2c_spi_bridge_tb.sv
module i2c_spi_bridge_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         NCS        = 4;
    localparam int         DEPTH      = 200;
    localparam logic [6:0] ADDR       = 7'h51;
    localparam logic [NCS-1:0] ALL_HI = '1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bl_start = 1'b0;
    logic           bl_stop = 1'b0;
    logic           bl_byte_vld = 1'b0;
    logic [7:0]     bl_byte = 8'h00;
    logic           bl_rd_req = 1'b0;
    logic           bl_ack_vld;
    logic           bl_ack;
    logic [7:0]     bl_rd_data;
    logic           busy;
    logic [7:0]     cfg;
    logic           sh_start;
    logic [7:0]     sh_tx;
    logic           sh_done = 1'b0;
    logic [7:0]     sh_rx = 8'h00;
    logic [NCS-1:0] cs_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_spi_bridge #(
        .DEPTH    (DEPTH),
        .NUM_CS   (NCS),
        .SKIP_CS2 (1'b1),
        .SLV_ADDR (ADDR)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bl_start_i    (bl_start),
        .bl_stop_i     (bl_stop),
        .bl_byte_vld_i (bl_byte_vld),
        .bl_byte_i     (bl_byte),
        .bl_rd_req_i   (bl_rd_req),
        .bl_ack_vld_o  (bl_ack_vld),
        .bl_ack_o      (bl_ack),
        .bl_rd_data_o  (bl_rd_data),
        .busy_o        (busy),
        .cfg_o         (cfg),
        .sh_start_o    (sh_start),
        .sh_tx_o       (sh_tx),
        .sh_done_i     (sh_done),
        .sh_rx_i       (sh_rx),
        .cs_n_o        (cs_n)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference model: expected SPI bytes, their line and buffer slot
    logic [7:0]     exp_tx_q [$];
    logic [NCS-1:0] exp_cs_q [$];
    int             exp_pos_q [$];
    logic [7:0]     mbuf [DEPTH];
    int             pend = 0;
    int             nstarts = 0;
    logic [7:0]     ret_byte = 8'h00;

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    // shifter stand-in and per-clock comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (exp_tx_q.size() == 0 && pend == 0 && !sh_done) begin
                chk(cs_n == ALL_HI, "R11", "lines idle outside transaction", int'(cs_n), int'(ALL_HI));
            end
            if (sh_done) sh_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    sh_done = 1'b1;
                    sh_rx   = ret_byte;
                end
            end
            if (sh_start) begin
                nstarts++;
                if (exp_tx_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected SPI byte", int'(sh_tx), 0);
                    ret_byte = 8'h00;
                end else begin
                    logic [7:0]     etx;
                    logic [NCS-1:0] ecs;
                    int             epos;
                    etx  = exp_tx_q.pop_front();
                    ecs  = exp_cs_q.pop_front();
                    epos = exp_pos_q.pop_front();
                    chk(sh_tx == etx, "R4", "SPI byte order", int'(sh_tx), int'(etx));
                    chk(cs_n == ecs, "R3", "selected line", int'(cs_n), int'(ecs));
                    ret_byte   = etx ^ 8'h5A;
                    mbuf[epos] = ret_byte;
                end
                pend = 2;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) bl_start = 1'b1;
        @(negedge clk) bl_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) bl_stop = 1'b1;
        @(negedge clk) bl_stop = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] b, output bit acked, output bit strobed);
        @(negedge clk) begin
            bl_byte_vld = 1'b1;
            bl_byte     = b;
        end
        @(negedge clk) bl_byte_vld = 1'b0;
        acked   = bl_ack;
        strobed = bl_ack_vld;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit a, s;
        xfer_byte(b, a, s);
        chk(s == 1'b1, req, "ack strobe", int'(s), 1);
        chk(a == exp_ack, req, "ack value", int'(a), int'(exp_ack));
    endtask

    task automatic read_byte(input logic [7:0] exp, input string req);
        @(negedge clk) bl_rd_req = 1'b1;
        @(negedge clk) bl_rd_req = 1'b0;
        chk(bl_rd_data == exp, req, "read byte", int'(bl_rd_data), int'(exp));
    endtask

    task automatic write_txn(input logic [7:0] fn, input int line, input int n,
                             input logic [7:0] seed, input bit end_rs);
        pulse_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R2");
        send_byte(fn, 1'b1, "R3");
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = seed + 8'(k * 7);
            if (k < DEPTH) begin
                exp_tx_q.push_back(b);
                exp_cs_q.push_back(~(NCS'(1) << line));
                exp_pos_q.push_back(k);
                send_byte(b, 1'b1, "R4");
            end else begin
                send_byte(b, 1'b0, "R8");
            end
        end
        if (end_rs) pulse_start();
        else pulse_stop();
    endtask

    task automatic wait_quiet(input string req);
        int guard = 0;
        while ((exp_tx_q.size() != 0 || pend != 0 || sh_done) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, req, "busy after transaction", int'(busy), 0);
    endtask

    task automatic read_back(input int n, input string req);
        pulse_start();
        send_byte({ADDR, 1'b1}, 1'b1, "R2");
        for (int k = 0; k < n; k++) begin
            read_byte(mbuf[k], req);
        end
        pulse_stop();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        bit got;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cs_n == ALL_HI, "R1", "lines after reset", int'(cs_n), int'(ALL_HI));
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(cfg == 8'h00, "R1", "cfg after reset", int'(cfg), 0);
        chk(bl_ack_vld == 1'b0, "R1", "no ack strobe after reset", int'(bl_ack_vld), 0);

        // R4/R5: short write to line 0 ended by stop
        base = nstarts;
        write_txn(8'h01, 0, 3, 8'h10, 1'b0);
        wait_quiet("R4");
        chk(nstarts - base == 3, "R4", "bytes in transaction", nstarts - base, 3);
        read_back(3, "R5");

        // R6: line 3, ended by repeated start, then busy refusal and polling
        base = nstarts;
        write_txn(8'h08, 3, 5, 8'hC3, 1'b1);
        send_byte({ADDR, 1'b1}, 1'b0, "R6");
        pulse_stop();
        got = 1'b0;
        for (int t = 0; t < 200 && !got; t++) begin
            bit a, s;
            pulse_start();
            xfer_byte({ADDR, 1'b1}, a, s);
            pulse_stop();
            got = a;
        end
        chk(got, "R6", "poll eventually acked", int'(got), 1);
        chk(exp_tx_q.size() == 0, "R6", "ack only after all bytes", exp_tx_q.size(), 0);
        wait_quiet("R6");
        chk(nstarts - base == 5, "R4", "bytes in transaction", nstarts - base, 5);
        read_back(5, "R5");

        // R7: configure function
        base = nstarts;
        pulse_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R2");
        send_byte(8'hF0, 1'b1, "R7");
        send_byte(8'h2D, 1'b1, "R7");
        send_byte(8'h77, 1'b0, "R7");
        pulse_stop();
        repeat (10) @(negedge clk);
        chk(cfg == 8'h2D, "R7", "control byte", int'(cfg), 8'h2D);
        chk(nstarts == base, "R7", "no transaction", nstarts - base, 0);
        chk(busy == 1'b0, "R7", "not busy", int'(busy), 0);

        // R9: function byte only
        pulse_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R2");
        send_byte(8'h02, 1'b1, "R9");
        pulse_stop();
        repeat (10) @(negedge clk);
        chk(nstarts == base, "R9", "no transaction", nstarts - base, 0);
        chk(busy == 1'b0, "R9", "not busy", int'(busy), 0);

        // R10: absent line 2 and a malformed function byte
        pulse_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R2");
        send_byte(8'h04, 1'b1, "R10");
        send_byte(8'h99, 1'b0, "R10");
        pulse_stop();
        pulse_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R2");
        send_byte(8'h03, 1'b1, "R10");
        send_byte(8'h66, 1'b0, "R10");
        pulse_stop();
        repeat (10) @(negedge clk);
        chk(nstarts == base, "R10", "no transaction", nstarts - base, 0);
        read_back(2, "R10");

        // R2: foreign address ignored
        pulse_start();
        send_byte({7'h22, 1'b0}, 1'b0, "R2");
        send_byte(8'h01, 1'b0, "R2");
        send_byte(8'h44, 1'b0, "R2");
        pulse_stop();
        repeat (10) @(negedge clk);
        chk(nstarts == base, "R2", "no transaction", nstarts - base, 0);

        // R8: capacity limit on line 1
        base = nstarts;
        write_txn(8'h02, 1, DEPTH + 1, 8'h01, 1'b0);
        wait_quiet("R8");
        chk(nstarts - base == DEPTH, "R8", "capped length", nstarts - base, DEPTH);
        read_back(DEPTH, "R8");

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule